// File: doc/BRIEF.md
# Dithered Gain-Calibration Correlator Loop

This block trims the reference voltage of a pipelined converter's front stages while normal conversions go on. On every accepted sample it produces a pseudo-random calibration symbol per calibrated stage. The symbol is either +1 or -1, and it drives a one-bit injection DAC in that stage. The back end later returns the digitised stage output, and a slow accurate converter supplies the digitised dither amplitude. For each stage the block subtracts the expected dither contribution, which is the symbol times the amplitude, to form an error term. It multiplies that error by the same symbol, delayed so that it lines up with the back-end latency. It then divides the product by a power of two and adds it to a wide saturating accumulator.

The top bits of each accumulator, read as offset binary, form the trim code for that stage's reference DAC. An update is made only when the caller flags the sample as lying in a region where the back-end gain error averages out. Each stage has its own generator and accumulator and is calibrated on its own. Only the digital part of the loop is modelled here: the analog stages and the converters are not.

Top module: `gain_cal_loop`

## Requirements
- R1: While reset is asserted, and on the first clock edge after reset, every accumulator is zero and every trim code equals midscale, 2^(TRIM_W-1).
- R2: Each stage's symbol appears on its bit of `dither_o`, where 1 means +1 and 0 means -1. The symbol comes from a 23-bit maximal-length LFSR (polynomial x^23+x^18+1). Over 4096 consecutive samples its count of ones lies between 1843 and 2253.
- R3: The stages use different LFSR seeds. Over 4096 consecutive samples, the two stages' symbols agree on between 1843 and 2253 samples.
- R4: The symbol used in a correlation is the one presented on `dither_o` exactly LAT samples earlier.
- R5: On an updating sample, err = be - s*amp and corr = s*err, where be is a signed back-end code, amp is an unsigned amplitude and s is ±1. The step is floor(corr / 2^SHIFT), an arithmetic right shift, and the step is added to the accumulator.
- R6: If a stage's `qualify_i` bit is low on a sample, that stage's accumulator and trim code do not change.
- R7: When `sample_en` is low, neither `dither_o` nor any trim code changes.
- R8: The first LAT samples after reset make no accumulator update, whatever the inputs are.
- R9: The accumulator is ACC_W = TRIM_W+SHIFT+GUARD bits wide, signed. A sum above 2^(ACC_W-1)-1 or below -2^(ACC_W-1) is clamped to that bound.
- R10: The trim code is the accumulator's top TRIM_W bits with the most significant bit inverted. This equals floor(acc / 2^(ACC_W-TRIM_W)) + 2^(TRIM_W-1).
- R11: The stages are independent. One stage's inputs never affect another stage's trim code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | One converter sample is accepted on this edge |
| qualify_i | input | NUM_STAGES | Per stage: the residue lies in a region where an update is allowed |
| be_code_i | input | NUM_STAGES*DATA_W | Per stage: signed back-end code, stage s at bits [s*DATA_W +: DATA_W] |
| amp_i | input | NUM_STAGES*AMP_W | Per stage: unsigned digitised dither amplitude |
| dither_o | output | NUM_STAGES | Per stage: calibration symbol, 1 = +1 and 0 = -1 |
| trim_o | output | NUM_STAGES*TRIM_W | Per stage: offset-binary reference trim code |

## Verification
The bench runs a small configuration: SHIFT=2, TRIM_W=4, LAT=3, with 8-bit codes. It keeps its own arithmetic model fed by the symbols seen on `dither_o`. This catches an off-by-one symbol delay, a logical instead of arithmetic shift, and a wrong sign in the error or correlation, because each of these makes the trim codes drift away from the model within a few samples. Both accumulators are driven fully into each rail with correlated input. A design that wraps instead of clamping would flip its trim code from 15 to 0. The bench also restarts from reset with large inputs, which exposes any update during the warm-up window. A long run with updates turned off checks that the symbols are balanced, that the two stages are not copies of each other, and that the trim codes stay still.

// File: rtl/gcal_pkg.sv
// Shared helpers for the gain-calibration loop: LFSR step and per-stage seed.
// Assumes the 23-bit polynomial x^23+x^18+1, which is maximal length.
package gcal_pkg;
    localparam int LFSR_W = 23;

    // Distinct, never-zero seed for stage idx
    function automatic logic [LFSR_W-1:0] lfsr_seed(input int idx);
        logic [LFSR_W-1:0] s;
        s = LFSR_W'(32'h005A_3C91 ^ (idx * 32'h0013_579B));
        if (s == '0) s = LFSR_W'(1);
        return s;
    endfunction

    // One Fibonacci step
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[22] ^ s[17]};
    endfunction
endpackage

// File: rtl/gcal_symbol_gen.sv
// Per-stage symbol source: LFSR advanced once per accepted sample, plus a
// LAT-deep delay line that aligns the symbol with the back-end code, and a
// matching valid line that blocks updates until the delay line is full.
// Assumes LAT >= 1.
module gcal_symbol_gen
    import gcal_pkg::*;
#(
    parameter int SEED_IDX = 0,
    parameter int LAT      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    output logic sym_now_o,
    output logic sym_del_o,
    output logic del_valid_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LAT-1:0]    dly_q;
    logic [LAT-1:0]    vld_q;

    // Advance generator and delay lines on each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= lfsr_seed(SEED_IDX);
            dly_q  <= '0;
            vld_q  <= '0;
        end else if (sample_en) begin
            lfsr_q <= lfsr_next(lfsr_q);
            dly_q  <= LAT'({dly_q, lfsr_q[0]});
            vld_q  <= LAT'({vld_q, 1'b1});
        end
    end

    assign sym_now_o   = lfsr_q[0];
    assign sym_del_o   = dly_q[LAT-1];
    assign del_valid_o = vld_q[LAT-1];
endmodule

// File: rtl/gcal_accum.sv
// Per-stage correlator and saturating accumulator. Forms err = be - s*amp,
// corr = s*err, step = corr >>> SHIFT, then clamps acc+step to the signed
// ACC_W range. Trim is the top TRIM_W bits in offset binary.
// Assumes ACC_W <= 63.
module gcal_accum #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 10,
    parameter int SHIFT  = 21,
    parameter int TRIM_W = 7,
    parameter int GUARD  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     update_en,
    input  logic                     sym_i,
    input  logic signed [DATA_W-1:0] be_i,
    input  logic        [AMP_W-1:0]  amp_i,
    output logic        [TRIM_W-1:0] trim_o
);
    localparam int ACC_W = TRIM_W + SHIFT + GUARD;
    localparam int EW    = ((DATA_W > AMP_W + 1) ? DATA_W : AMP_W + 1) + 1;
    localparam int CW    = EW + 1;
    localparam int SW    = ((ACC_W > CW) ? ACC_W : CW) + 1;
    localparam logic signed [SW-1:0] ACC_MAX = SW'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] ACC_MIN = -ACC_MAX - SW'(1);
    localparam logic [TRIM_W-1:0]    MSB_ONE = {1'b1, {(TRIM_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic signed [EW-1:0]    be_x, amp_x, err;
    logic signed [CW-1:0]    corr, step;
    logic signed [SW-1:0]    sum;

    // Error, correlation, scaling and clamped sum
    always_comb begin
        be_x  = EW'(be_i);
        amp_x = EW'($signed({1'b0, amp_i}));
        err   = sym_i ? (be_x - amp_x) : (be_x + amp_x);
        corr  = sym_i ? CW'(err) : -CW'(err);
        step  = corr >>> SHIFT;
        sum   = SW'(acc_q) + SW'(step);
        if (sum > ACC_MAX)      acc_d = ACC_W'(ACC_MAX);
        else if (sum < ACC_MIN) acc_d = ACC_W'(ACC_MIN);
        else                    acc_d = ACC_W'(sum);
    end

    // Accumulator register, loaded only on qualified samples
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (update_en) acc_q <= acc_d;
    end

    assign trim_o = acc_q[ACC_W-1 -: TRIM_W] ^ MSB_ONE;
endmodule

// File: rtl/gain_cal_loop.sv
// Top of the background gain-calibration loop: one symbol generator and one
// accumulator per calibrated stage, replicated by generate. An update needs
// sample_en, the stage's qualify bit and a filled symbol delay line.
module gain_cal_loop #(
    parameter int NUM_STAGES = 2,
    parameter int DATA_W     = 12,
    parameter int AMP_W      = 10,
    parameter int SHIFT      = 21,
    parameter int TRIM_W     = 7,
    parameter int GUARD      = 2,
    parameter int LAT        = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_en,
    input  logic [NUM_STAGES-1:0]        qualify_i,
    input  logic [NUM_STAGES*DATA_W-1:0] be_code_i,
    input  logic [NUM_STAGES*AMP_W-1:0]  amp_i,
    output logic [NUM_STAGES-1:0]        dither_o,
    output logic [NUM_STAGES*TRIM_W-1:0] trim_o
);
    genvar s;
    generate
        for (s = 0; s < NUM_STAGES; s++) begin : g_stage
            logic sym_del, del_valid, upd;

            gcal_symbol_gen #(.SEED_IDX(s), .LAT(LAT)) sym_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .sample_en  (sample_en),
                .sym_now_o  (dither_o[s]),
                .sym_del_o  (sym_del),
                .del_valid_o(del_valid)
            );

            assign upd = sample_en & qualify_i[s] & del_valid;

            gcal_accum #(
                .DATA_W(DATA_W), .AMP_W(AMP_W), .SHIFT(SHIFT),
                .TRIM_W(TRIM_W), .GUARD(GUARD)
            ) acc_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .update_en(upd),
                .sym_i    (sym_del),
                .be_i     ($signed(be_code_i[s*DATA_W +: DATA_W])),
                .amp_i    (amp_i[s*AMP_W +: AMP_W]),
                .trim_o   (trim_o[s*TRIM_W +: TRIM_W])
            );
        end
    endgenerate
endmodule

// File: rtl/gain_cal_loop_chk.sv
// Checker for gain_cal_loop: reset value, hold behaviour and warm-up window,
// observed at the top-level ports. Bound to every gain_cal_loop instance.
module gain_cal_loop_chk #(
    parameter int NUM_STAGES = 2,
    parameter int TRIM_W     = 7,
    parameter int LAT        = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sample_en,
    input logic [NUM_STAGES-1:0]        qualify_i,
    input logic [NUM_STAGES-1:0]        dither_o,
    input logic [NUM_STAGES*TRIM_W-1:0] trim_o
);
    localparam int CNT_W = $clog2(LAT + 1) + 1;
    localparam logic [TRIM_W-1:0] MID = {1'b1, {(TRIM_W-1){1'b0}}};

    logic [CNT_W-1:0] smp_cnt_q;

    // Samples since reset, saturating at LAT
    always_ff @(posedge clk) begin
        if (!rst_n)                                     smp_cnt_q <= '0;
        else if (sample_en && smp_cnt_q < CNT_W'(LAT))  smp_cnt_q <= smp_cnt_q + CNT_W'(1);
    end

    AST_DITHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(dither_o)); // R7

    AST_WARMUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_cnt_q < CNT_W'(LAT)) |=> $stable(trim_o)); // R8

    genvar s;
    generate
        for (s = 0; s < NUM_STAGES; s++) begin : g_chk
            AST_RESET_MIDSCALE: assert property (@(posedge clk)
                !rst_n |=> (trim_o[s*TRIM_W +: TRIM_W] == MID)); // R1

            AST_UNQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !(sample_en && qualify_i[s]) |=> $stable(trim_o[s*TRIM_W +: TRIM_W])); // R6
        end
    endgenerate
endmodule

bind gain_cal_loop gain_cal_loop_chk #(
    .NUM_STAGES(NUM_STAGES), .TRIM_W(TRIM_W), .LAT(LAT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .qualify_i(qualify_i),
    .dither_o(dither_o), .trim_o(trim_o)
);

// File: tb/gain_cal_loop_tb_top.sv
module gain_cal_loop_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS     = 2;
    localparam int DW     = 8;
    localparam int AW     = 6;
    localparam int SHIFT  = 2;
    localparam int TW     = 4;
    localparam int GUARD  = 2;
    localparam int LAT    = 3;
    localparam int ACC_W  = TW + SHIFT + GUARD;
    localparam int AMAX   = (1 << (ACC_W - 1)) - 1;
    localparam int AMIN   = -(1 << (ACC_W - 1));
    localparam int HMAX   = 16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic [NS-1:0] qualify_i = '0;
    logic [NS*DW-1:0] be_code_i = '0;
    logic [NS*AW-1:0] amp_i = '0;
    logic [NS-1:0] dither_o;
    logic [NS*TW-1:0] trim_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_smp = 0;
    int acc_m [NS];
    bit hist [NS][HMAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    gain_cal_loop #(
        .NUM_STAGES(NS), .DATA_W(DW), .AMP_W(AW), .SHIFT(SHIFT),
        .TRIM_W(TW), .GUARD(GUARD), .LAT(LAT)
    ) dut_i (.*);

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int exp_trim(input int s);
        return (acc_m[s] >>> (ACC_W - TW)) + (1 << (TW - 1));
    endfunction

    // Symbol due for correlation on the next sample edge (R4)
    function automatic int sym_due(input int s);
        if (n_smp < LAT) return 0;
        return hist[s][n_smp - LAT] ? 1 : 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sample_en = 1'b0; qualify_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_smp = 0;
        for (int s = 0; s < NS; s++) acc_m[s] = 0;
        for (int s = 0; s < NS; s++) check($sformatf("R1 stage %0d reset trim", s),
                                           int'(trim_o[s*TW +: TW]), 1 << (TW - 1));
    endtask

    // Called at a negedge: drive one cycle, advance model, check after the edge
    task automatic do_cycle(input bit se, input bit [NS-1:0] q,
                            input int be0, input int be1, input int a0, input int a1,
                            input string tag);
        logic [NS-1:0] d_pre;
        int be [NS];
        int am [NS];
        be[0] = be0; be[1] = be1; am[0] = a0; am[1] = a1;
        d_pre = dither_o;
        sample_en = se;
        qualify_i = q;
        for (int s = 0; s < NS; s++) begin
            be_code_i[s*DW +: DW] = DW'(be[s]);
            amp_i[s*AW +: AW]     = AW'(am[s]);
        end
        if (se) begin
            for (int s = 0; s < NS; s++) begin
                if (n_smp >= LAT && q[s]) begin
                    int sg, err, corr, sum;
                    sg   = hist[s][n_smp - LAT] ? 1 : -1;
                    err  = be[s] - sg * am[s];
                    corr = sg * err;
                    sum  = acc_m[s] + (corr >>> SHIFT);
                    acc_m[s] = (sum > AMAX) ? AMAX : (sum < AMIN) ? AMIN : sum;
                end
                hist[s][n_smp] = d_pre[s];
            end
            if (n_smp < HMAX - 1) n_smp++;
        end
        @(posedge clk);
        @(negedge clk);
        for (int s = 0; s < NS; s++)
            check($sformatf("%s stage %0d trim", tag, s), int'(trim_o[s*TW +: TW]), exp_trim(s));
        if (!se) check("R7 dither held", int'(dither_o), int'(d_pre));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ones [NS];
        int agree;
        do_reset();

        // R8: large correlated input during warm-up must leave trim at midscale
        for (int k = 0; k < LAT; k++) begin
            do_cycle(1'b1, 2'b11, 127, -128, 0, 0, "R8 warm-up");
            for (int s = 0; s < NS; s++)
                check("R8 warm-up midscale", int'(trim_o[s*TW +: TW]), 1 << (TW - 1));
        end

        // R4 R5 R6 R7 R11: random sweep against the arithmetic model
        for (int k = 0; k < 3000; k++) begin
            bit se;
            se = ($urandom_range(0, 3) != 0);
            do_cycle(se, NS'($urandom), $urandom_range(0, 255) - 128,
                     $urandom_range(0, 255) - 128, $urandom_range(0, 63),
                     $urandom_range(0, 63), "R4,R5,R6,R11 sweep");
        end

        // R11: stage 0 only qualified, stage 1 must stay put
        for (int k = 0; k < 200; k++)
            do_cycle(1'b1, 2'b01, $urandom_range(0, 255) - 128, 127, 5, 63, "R11 isolation");

        // R9 R10: correlated drive into the upper rail, then the lower rail
        for (int k = 0; k < 300; k++)
            do_cycle(1'b1, 2'b11, sym_due(0) ? 127 : -128, sym_due(1) ? 127 : -128,
                     0, 0, "R9 upper");
        for (int s = 0; s < NS; s++)
            check("R9,R10 upper rail trim", int'(trim_o[s*TW +: TW]), (1 << TW) - 1);
        for (int k = 0; k < 300; k++)
            do_cycle(1'b1, 2'b11, sym_due(0) ? -128 : 127, sym_due(1) ? -128 : 127,
                     0, 0, "R9 lower");
        for (int s = 0; s < NS; s++)
            check("R9,R10 lower rail trim", int'(trim_o[s*TW +: TW]), 0);

        // R2 R3 R6: symbol statistics with updates disabled
        for (int s = 0; s < NS; s++) ones[s] = 0;
        agree = 0;
        for (int k = 0; k < 4096; k++) begin
            for (int s = 0; s < NS; s++) ones[s] += int'(dither_o[s]);
            if (dither_o[0] == dither_o[1]) agree++;
            do_cycle(1'b1, 2'b00, 100, -100, 10, 10, "R6 unqualified");
        end
        for (int s = 0; s < NS; s++) begin
            int in_range;
            in_range = (ones[s] >= 1843 && ones[s] <= 2253) ? 1 : 0;
            check($sformatf("R2 stage %0d ones=%0d balanced", s, ones[s]), in_range, 1);
        end
        check($sformatf("R3 agreement=%0d", agree), (agree >= 1843 && agree <= 2253) ? 1 : 0, 1);

        // R1: reset mid-run returns to midscale
        do_reset();
        do_cycle(1'b1, 2'b11, 50, 50, 3, 3, "R8 after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule